// File: doc/BRIEF.md
# Debounced Digital-Input Serializer with Checksummed Status Frame

This block is the device end of a serial input module. It takes eight digital inputs, filters each one with a debounce counter whose length is chosen by two select pins, and shows the filtered byte to a host over a shift register clocked by the host. The host drops chip select to capture a snapshot. It then clocks out the input byte, most significant bit first. In 16-bit mode a status byte follows the input byte. The status byte carries a 5-bit checksum of the captured inputs and three supply and temperature flags.

Several devices can be chained. Each device shifts its serial input into the low end of its register, so the frames of devices further down the chain follow this device's own frame in the same burst. The frame of the device wired to the host arrives first. A fault output goes high while the overtemperature or undervoltage alarm input is present.

All pins are sampled by the block clock. The raw inputs and the alarm inputs pass through a two-stage synchronizer. The debounce counters advance on a tick that is divided down from the clock.

Top module: `dis_serializer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `sdo` and `fault` are 0 and the filtered input byte is 0x00.
- R2: When `mode8` is 1 at the falling edge of `csn`, the frame is 8 bits long and holds the filtered input byte with bit 7 first.
- R3: When `mode8` is 0 at the falling edge of `csn`, the frame is 16 bits long: the filtered input byte first, then the status byte, each sent bit 7 first.
- R4: Status bits 7:3 hold the CRC of the captured input byte. The polynomial is x^5+x^4+x^2+1, the seed is zero, and the byte is processed bit 7 first.
- R5: Status bit 1 equals the synchronized `ot_alarm`. Status bit 2 is the inverse of `uv_alarm`. Status bit 0 is the inverse of `uv_warn`.
- R6: Input and alarm values are captured only on the clock edge that sees `csn` fall. Changes after that edge do not alter the frame being shifted.
- R7: `fault` equals (`ot_alarm` OR `uv_alarm`) after the two synchronizer stages plus one register, which is three clock edges after the pin changes. `uv_warn` does not affect it.
- R8: Each falling edge of `sclk` while `csn` is low shifts the frame up by one bit. `sdi` enters at the bottom, so `sdi` data appears on `sdo` after 8 bits in 8-bit mode and after 16 bits in 16-bit mode.
- R9: With `dbsel` = 00 there is no filtering. An input change reaches the filtered byte three clock edges after the pin changes.
- R10: With `dbsel` = 01, 10 or 11, a filtered bit changes only after its synchronized input has differed from it on 2, 6 or 12 consecutive ticks respectively. A tick occurs every 4 clocks. Shorter pulses are rejected.
- R11: While `csn` is high, `sclk` edges do not move the shift register, and `sdo` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| din | input | 8 | Raw digital inputs |
| dbsel | input | 2 | Debounce setting: 00 none, 01 short, 10 medium, 11 long |
| mode8 | input | 1 | 1 selects 8-bit frames, 0 selects 16-bit frames |
| ot_alarm | input | 1 | Overtemperature condition present |
| uv_alarm | input | 1 | Undervoltage alarm present |
| uv_warn | input | 1 | Undervoltage warning present |
| csn | input | 1 | Chip select, active low; the falling edge captures the frame |
| sclk | input | 1 | Shift clock; the register shifts on its falling edge |
| sdi | input | 1 | Serial data from the next device in the chain |
| sdo | output | 1 | Serial data toward the host, top bit of the register |
| fault | output | 1 | High while overtemperature or undervoltage alarm is present |

## Verification
The assertions assume the following about the inputs:
- `csn` and `sclk` are synchronous to `clk`, and each `sclk` level lasts at least one clock.
- `dbsel` and `mode8` change only while the inputs are settled and no frame is in progress.

The bench keeps to these assumptions. It drives every pin on the falling clock edge and holds `sclk` high and low for one full clock each. It changes `dbsel` only after the filtered state has caught up with the pins.

Under those conditions, a filtered bit can only flip in the cycle after a tick, and an idle `sclk` with chip select high leaves `sdo` untouched.

// File: rtl/dis_pkg.sv
package dis_pkg;
    localparam int IN_W    = 8;
    localparam int FRAME_W = 2 * IN_W;
    localparam int CRC_W   = 5;
    localparam logic [CRC_W-1:0] CRC_POLY = 5'h15;

    // Status byte layout: {crc[4:0], supply_ok, overtemp, warn_clear}
    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             supply_ok;
        logic             overtemp;
        logic             warn_clear;
    } status_t;

    function automatic logic [CRC_W-1:0] crc5_msb(input logic [IN_W-1:0] data);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = IN_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction
endpackage

// File: rtl/dis_sync.sv
module dis_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_raw,
    output logic [W-1:0] out_sync
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = in_raw;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/dis_tick.sv
module dis_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/dis_debounce.sv
module dis_debounce #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          filt
);
    typedef struct packed {
        logic          level;
        logic [CW-1:0] run;
    } db_state_t;

    db_state_t st_d, st_q;
    logic [CW:0] run_next;

    always_comb begin
        st_d     = st_q;
        run_next = {1'b0, st_q.run} + 1'b1;
        if (raw == st_q.level) begin
            st_d.run = '0;
        end else if (limit == '0) begin
            st_d.level = raw;
            st_d.run   = '0;
        end else if (tick) begin
            if (run_next >= {1'b0, limit}) begin
                st_d.level = raw;
                st_d.run   = '0;
            end else begin
                st_d.run = run_next[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt = st_q.level;
endmodule

// File: rtl/dis_frame_shift.sv
module dis_frame_shift
    import dis_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csn,
    input  logic            sclk,
    input  logic            sdi,
    input  logic            mode8,
    input  logic [IN_W-1:0] in_byte,
    input  status_t         status,
    output logic            sdo
);
    typedef struct packed {
        logic               csn_prev;
        logic               sclk_prev;
        logic               short_frame;
        logic [FRAME_W-1:0] sr;
    } sh_state_t;

    sh_state_t st_d, st_q;
    logic capture, shift_now;

    always_comb begin
        st_d      = st_q;
        capture   = st_q.csn_prev && !csn;
        shift_now = st_q.sclk_prev && !sclk && !csn;
        if (capture) begin
            st_d.short_frame = mode8;
            st_d.sr          = mode8 ? {in_byte, {IN_W{1'b0}}} : {in_byte, status};
        end else if (shift_now) begin
            if (st_q.short_frame) begin
                st_d.sr[FRAME_W-1:IN_W] = {st_q.sr[FRAME_W-2:IN_W], sdi};
            end else begin
                st_d.sr = {st_q.sr[FRAME_W-2:0], sdi};
            end
        end
        st_d.csn_prev  = csn;
        st_d.sclk_prev = sclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.csn_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo = st_q.sr[FRAME_W-1];
endmodule

// File: rtl/dis_serializer.sv
module dis_serializer
    import dis_pkg::*;
#(
    parameter int TICK_DIV    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DB_SHORT    = 2,
    parameter int DB_MEDIUM   = 6,
    parameter int DB_LONG     = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] din,
    input  logic [1:0]      dbsel,
    input  logic            mode8,
    input  logic            ot_alarm,
    input  logic            uv_alarm,
    input  logic            uv_warn,
    input  logic            csn,
    input  logic            sclk,
    input  logic            sdi,
    output logic            sdo,
    output logic            fault
);
    localparam int SW = IN_W + 3;
    localparam int CW = $clog2(DB_LONG + 1);

    typedef struct packed {
        logic fault;
    } top_state_t;

    logic [SW-1:0]   raw_vec, sync_vec;
    logic [IN_W-1:0] in_s, filt;
    logic            ot_s, uva_s, uvw_s;
    logic            tick;
    logic [CW-1:0]   limit;
    status_t         status;
    top_state_t      st_d, st_q;

    assign raw_vec = {uv_warn, uv_alarm, ot_alarm, din};

    dis_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .in_raw(raw_vec), .out_sync(sync_vec)
    );

    assign in_s  = sync_vec[IN_W-1:0];
    assign ot_s  = sync_vec[IN_W];
    assign uva_s = sync_vec[IN_W+1];
    assign uvw_s = sync_vec[IN_W+2];

    dis_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    always_comb begin
        case (dbsel)
            2'b01:   limit = CW'(DB_SHORT);
            2'b10:   limit = CW'(DB_MEDIUM);
            2'b11:   limit = CW'(DB_LONG);
            default: limit = '0;
        endcase
    end

    for (genvar g = 0; g < IN_W; g++) begin : g_db
        dis_debounce #(.CW(CW)) u_db (
            .clk(clk), .rst_n(rst_n), .raw(in_s[g]), .tick(tick),
            .limit(limit), .filt(filt[g])
        );
    end

    always_comb begin
        status.crc        = crc5_msb(filt);
        status.supply_ok  = !uva_s;
        status.overtemp   = ot_s;
        status.warn_clear = !uvw_s;
    end

    dis_frame_shift u_shift (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .sdi(sdi),
        .mode8(mode8), .in_byte(filt), .status(status), .sdo(sdo)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fault = ot_s | uva_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault = st_q.fault;
endmodule

// File: rtl/dis_serializer_chk.sv
module dis_serializer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       csn,
    input logic       sdo,
    input logic       fault,
    input logic       tick,
    input logic [7:0] filt,
    input logic [1:0] dbsel,
    input logic       ot_s,
    input logic       uva_s
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sdo && !fault && filt == 8'h00));

    // R7
    fault_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault == $past(ot_s || uva_s));

    // R10
    filt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) && ($past(dbsel) != 2'b00) |-> $past(tick));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csn && $past(csn)) |-> $stable(sdo));
endmodule

bind dis_serializer dis_serializer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sdo(sdo), .fault(fault),
    .tick(tick), .filt(filt), .dbsel(dbsel), .ot_s(ot_s), .uva_s(uva_s)
);

// File: tb/dis_serializer_tb.sv
module dis_serializer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic [1:0] dbsel = 2'b00;
    logic       mode8 = 1'b0;
    logic       ot_alarm = 1'b0, uv_alarm = 1'b0, uv_warn = 1'b0;
    logic       csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic       sdo, fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dis_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .dbsel(dbsel), .mode8(mode8),
        .ot_alarm(ot_alarm), .uv_alarm(uv_alarm), .uv_warn(uv_warn),
        .csn(csn), .sclk(sclk), .sdi(sdi), .sdo(sdo), .fault(fault)
    );

    // ---------------- behavioural reference model ----------------
    logic [10:0] m_pipe [2];
    int          m_phase;
    logic [7:0]  m_level;
    int          m_run [8];
    logic        m_csn_old, m_sclk_old, m_len8;
    logic [15:0] m_sr;
    logic        m_fault;

    function automatic int ref_crc(input int d);
        int v = d << 5;
        for (int b = 12; b >= 5; b--) begin
            if (((v >> b) & 1) != 0) v = v ^ (32'h35 << (b - 5));
        end
        return v & 31;
    endfunction

    function automatic int ticks_for(input logic [1:0] s);
        case (s)
            2'b01:   return 2;
            2'b10:   return 6;
            2'b11:   return 12;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] full_frame(input logic [7:0] d, input logic ot,
                                               input logic uva, input logic uvw);
        logic [4:0] c = 5'(ref_crc(int'(d)));
        return {d, c, ~uva, ot, ~uvw};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pipe[0] = '0; m_pipe[1] = '0; m_phase = 0; m_level = '0;
            for (int i = 0; i < 8; i++) m_run[i] = 0;
            m_csn_old = 1'b1; m_sclk_old = 1'b0; m_len8 = 1'b0;
            m_sr = '0; m_fault = 1'b0;
        end else begin
            logic [10:0] syn;
            logic        tk;
            int          lim;
            syn = m_pipe[1];
            tk  = (m_phase == 3);
            lim = ticks_for(dbsel);
            if (m_csn_old && !csn) begin
                m_len8 = mode8;
                m_sr   = mode8 ? {m_level, 8'h00}
                               : full_frame(m_level, syn[8], syn[9], syn[10]);
            end else if (m_sclk_old && !sclk && !csn) begin
                if (m_len8) m_sr[15:8] = {m_sr[14:8], sdi};
                else        m_sr = {m_sr[14:0], sdi};
            end
            m_csn_old  = csn;
            m_sclk_old = sclk;
            m_fault    = syn[8] | syn[9];
            for (int i = 0; i < 8; i++) begin
                if (syn[i] == m_level[i]) m_run[i] = 0;
                else if (lim == 0) begin m_level[i] = syn[i]; m_run[i] = 0; end
                else if (tk) begin
                    if (m_run[i] + 1 >= lim) begin m_level[i] = syn[i]; m_run[i] = 0; end
                    else m_run[i] = m_run[i] + 1;
                end
            end
            m_pipe[1] = m_pipe[0];
            m_pipe[0] = {uv_warn, uv_alarm, ot_alarm, din};
            m_phase   = (m_phase == 3) ? 0 : m_phase + 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (sdo !== m_sr[15]) begin
                fails++;
                $display("FAIL R8 cycle sdo actual=%0b expected=%0b at %0t", sdo, m_sr[15], $time);
            end
            checks++;
            if (fault !== m_fault) begin
                fails++;
                $display("FAIL R7 cycle fault actual=%0b expected=%0b at %0t", fault, m_fault, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_frame(input int nbits, input logic [7:0] down,
                              input int chg_at, input logic [7:0] chg_val,
                              output logic [31:0] got);
        got = '0;
        @(negedge clk);
        csn = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            got = {got[30:0], sdo};
            if (i == chg_at) din = chg_val;
            sdi  = (i < 8) ? down[7 - i] : 1'b0;
            sclk = 1'b1;
            @(negedge clk);
            sclk = 1'b0;
        end
        @(negedge clk);
        csn = 1'b1;
        sdi = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] got;
        idle(3);
        chk("R1 sdo in reset", 32'(sdo), 0);
        chk("R1 fault in reset", 32'(fault), 0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 sdo after reset", 32'(sdo), 0);
        read_frame(8, 8'h00, -1, 8'h00, got);
        chk("R1 filtered byte after reset", got[7:0], 8'h00);

        // R3 R4 R5 R9: 16-bit frame, healthy supply
        din = 8'hA5;
        idle(8);
        read_frame(16, 8'h00, -1, 8'h00, got);
        chk("R3 R4 R5 frame A5", got[15:0], full_frame(8'hA5, 0, 0, 0));

        // R7 R5: overtemperature
        ot_alarm = 1'b1;
        idle(5);
        chk("R7 fault on overtemp", 32'(fault), 1);
        read_frame(16, 8'h00, -1, 8'h00, got);
        chk("R5 overtemp bit", got[15:0], full_frame(8'hA5, 1, 0, 0));

        // R7 R5: undervoltage alarm
        ot_alarm = 1'b0; uv_alarm = 1'b1; din = 8'h80;
        idle(5);
        chk("R7 fault on undervoltage", 32'(fault), 1);
        read_frame(16, 8'h00, -1, 8'h00, got);
        chk("R4 R5 uv alarm frame 80", got[15:0], full_frame(8'h80, 0, 1, 0));

        // R7 R5: warning alone does not fault
        uv_alarm = 1'b0; uv_warn = 1'b1;
        idle(5);
        chk("R7 no fault on warning", 32'(fault), 0);
        read_frame(16, 8'h00, -1, 8'h00, got);
        chk("R5 warning bit", got[15:0], full_frame(8'h80, 0, 0, 1));
        uv_warn = 1'b0;

        // R2: 8-bit frame
        mode8 = 1'b1; din = 8'h3C;
        idle(6);
        read_frame(8, 8'h00, -1, 8'h00, got);
        chk("R2 8-bit frame", got[7:0], 8'h3C);

        // R8: chain in 8-bit mode
        read_frame(16, 8'h5A, -1, 8'h00, got);
        chk("R8 chain behind 8-bit frame", got[15:0], {8'h3C, 8'h5A});

        // R8: chain in 16-bit mode
        mode8 = 1'b0; din = 8'h81;
        idle(6);
        read_frame(24, 8'hC3, -1, 8'h00, got);
        chk("R8 chain behind 16-bit frame", got[23:0], {full_frame(8'h81, 0, 0, 0), 8'hC3});

        // R6: input change during a frame does not alter it
        read_frame(16, 8'h00, 3, 8'h18, got);
        chk("R6 frame frozen at capture", got[15:0], full_frame(8'h81, 0, 0, 0));
        din = 8'h81;
        idle(6);

        // R11: sclk with csn high leaves sdo alone
        din = 8'h80;
        idle(6);
        @(negedge clk); csn = 1'b0;
        @(negedge clk); csn = 1'b1;
        chk("R11 loaded msb", 32'(sdo), 1);
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b1; @(negedge clk);
            sclk = 1'b0; @(negedge clk);
        end
        chk("R11 sdo held with csn high", 32'(sdo), 1);

        // R9: no filtering, change seen three edges after the pin
        din = 8'h0F;
        idle(3);
        csn = 1'b0;
        @(negedge clk); csn = 1'b1;
        chk("R9 unfiltered capture", 32'(sdo), 0);
        idle(2);

        // R10: short setting rejects 3-clock glitch, same timing captures old value
        dbsel = 2'b01;
        idle(4);
        din = 8'hF0; idle(3); din = 8'h0F;
        idle(20);
        read_frame(8, 8'h00, -1, 8'h00, got);
        chk("R10 short glitch rejected", got[7:0], 8'h0F);
        din = 8'hF0;
        idle(3);
        csn = 1'b0;
        @(negedge clk); csn = 1'b1;
        chk("R10 filtered capture keeps old", 32'(sdo), 0);
        idle(20);
        read_frame(8, 8'h00, -1, 8'h00, got);
        chk("R10 short setting accepts held change", got[7:0], 8'hF0);

        // R10: long setting
        dbsel = 2'b11;
        idle(4);
        din = 8'h0F; idle(20); din = 8'hF0;
        idle(100);
        read_frame(8, 8'h00, -1, 8'h00, got);
        chk("R10 long glitch rejected", got[7:0], 8'hF0);
        din = 8'h0F;
        idle(80);
        read_frame(8, 8'h00, -1, 8'h00, got);
        chk("R10 long setting accepts held change", got[7:0], 8'h0F);

        // R10: medium setting
        dbsel = 2'b10;
        idle(4);
        din = 8'h55; idle(12); din = 8'h0F;
        idle(40);
        read_frame(8, 8'h00, -1, 8'h00, got);
        chk("R10 medium glitch rejected", got[7:0], 8'h0F);
        din = 8'h55;
        idle(40);
        read_frame(8, 8'h00, -1, 8'h00, got);
        chk("R10 medium setting accepts held change", got[7:0], 8'h55);

        idle(5);
        finish_run();
    end
endmodule